// File: doc/BRIEF.md
# Five-State Multicycle Register CPU

This block is a small programmable processor with two general registers, A and B, and four private registers: an instruction pointer, an instruction register, a data-address register and a data-buffer register. It executes a seven-operation instruction set whose operand order is destination first, then source. It reads one 32-bit instruction word from a read-only code port and uses a data memory port that writes on the clock edge and returns read data in the same cycle as the address.

Every instruction, whatever it does, spends exactly five clock cycles in a fixed cycle of phases:
1. fetch into the instruction register;
2. decode and register read;
3. arithmetic and data-address latch;
4. data memory access;
5. register and pointer write-back.

A phase that has no work for the current instruction still costs its cycle. Debug outputs show the phase, the instruction pointer and both general registers.

Top module: `cpu5_core`

## Requirements
- R1: Instruction word layout: opcode in bits 31:28, destination select in bit 27 (0 = A, 1 = B), source select in bit 26, reserved bits 25:16, address/immediate field in bits 15:0. The phase output `dbg_state` steps 0,1,2,3,4,0,… (0 fetch, 1 decode, 2 arithmetic, 3 memory, 4 write-back), one step per clock.
- R2: While synchronous reset is high, at the next clock edge the phase becomes 0 and the instruction pointer, A and B become 0.
- R3: Opcode 1 (register move) copies the source register into the destination register.
- R4: Opcode 2 (load) writes data memory at the address given by the field into the destination register.
- R5: Opcode 3 (store) writes the source register into data memory at the field address. The write enable is high only in phase 3, so the memory changes at the edge that ends phase 3.
- R6: Opcode 4 (immediate load) writes the field value itself into the destination register, with no memory read.
- R7: Opcode 5 (add) writes destination + source, modulo 2^16, into the destination register.
- R8: Opcode 6 (increment) writes destination + 1, modulo 2^16, into the destination register.
- R9: Opcode 7 (jump) loads the field into the instruction pointer. The pointer changes only at the edge that ends phase 4.
- R10: A and B change only at the edge that ends phase 4. Every non-jump instruction advances the pointer by 4, and the code address output equals the pointer.
- R11: Opcodes 0 and 8 to 15, and any word with a nonzero reserved bit, act as a five-cycle no-op. They change no register and write no memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| code_addr | output | IP_W | Address of the instruction being fetched |
| code_data | input | 32 | Instruction word at code_addr |
| dmem_addr | output | DATA_W | Data memory address |
| dmem_wdata | output | DATA_W | Data memory write data |
| dmem_rdata | input | DATA_W | Data memory read data for dmem_addr |
| dmem_we | output | 1 | Data memory write enable |
| dbg_state | output | 3 | Current phase |
| dbg_ip | output | IP_W | Instruction pointer |
| dbg_ax | output | DATA_W | Register A |
| dbg_bx | output | DATA_W | Register B |

## Verification
The bench uses the default widths: a 16-bit data path and a 16-bit pointer. At these widths, adding to 0xFFFF and incrementing it show the wrap-around directly. Directed programs check, at the exact cycle boundaries, the classic load-load-add-store sequence, jumps past skipped code and illegal words. Short random programs are then compared with a bench model of the register file.

// File: rtl/cpu5_pkg.sv
package cpu5_pkg;

  localparam int INSTR_W = 32;
  localparam int FIELD_W = 16;

  localparam logic [3:0] OPC_NOP   = 4'd0;
  localparam logic [3:0] OPC_MOVR  = 4'd1;
  localparam logic [3:0] OPC_LOAD  = 4'd2;
  localparam logic [3:0] OPC_STORE = 4'd3;
  localparam logic [3:0] OPC_MVI   = 4'd4;
  localparam logic [3:0] OPC_ADD   = 4'd5;
  localparam logic [3:0] OPC_INC   = 4'd6;
  localparam logic [3:0] OPC_JMP   = 4'd7;

  typedef enum logic [2:0] {
    ST_FETCH  = 3'd0,
    ST_DECODE = 3'd1,
    ST_EXEC   = 3'd2,
    ST_MEM    = 3'd3,
    ST_WRITE  = 3'd4
  } phase_e;

  function automatic logic word_legal(input logic [INSTR_W-1:0] w);
    return (w[25:16] == 10'd0) && (w[31:28] <= OPC_JMP);
  endfunction

  function automatic logic [3:0] word_opc(input logic [INSTR_W-1:0] w);
    return word_legal(w) ? w[31:28] : OPC_NOP;
  endfunction

  function automatic logic word_dst(input logic [INSTR_W-1:0] w);
    return w[27];
  endfunction

  function automatic logic word_src(input logic [INSTR_W-1:0] w);
    return w[26];
  endfunction

  function automatic logic [FIELD_W-1:0] word_field(input logic [INSTR_W-1:0] w);
    return w[FIELD_W-1:0];
  endfunction

endpackage

// File: rtl/cpu5_seq.sv
module cpu5_seq
  import cpu5_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  output phase_e phase
);

  phase_e phase_nx;

  always_comb begin
    if (phase == ST_WRITE) phase_nx = ST_FETCH;
    else                   phase_nx = phase_e'(phase + 3'd1);
  end

  always_ff @(posedge clk) begin
    if (rst) phase <= ST_FETCH;
    else     phase <= phase_nx;
  end

endmodule

// File: rtl/cpu5_regs.sv
module cpu5_regs #(
  parameter int DATA_W = 16,
  parameter int NREG   = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [SEL_W-1:0]       rd_a_sel,
  input  logic [SEL_W-1:0]       rd_b_sel,
  output logic [DATA_W-1:0]      rd_a,
  output logic [DATA_W-1:0]      rd_b,
  input  logic                   wr_en,
  input  logic [SEL_W-1:0]       wr_sel,
  input  logic [DATA_W-1:0]      wr_data,
  output logic [NREG*DATA_W-1:0] q_flat
);
  localparam int SEL_W = (NREG > 1) ? $clog2(NREG) : 1;

  logic [DATA_W-1:0] bank [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)                                      bank[g] <= '0;
      else if (wr_en && (wr_sel == SEL_W'(g)))      bank[g] <= wr_data;
    end
    assign q_flat[g*DATA_W +: DATA_W] = bank[g];
  end

  assign rd_a = bank[rd_a_sel];
  assign rd_b = bank[rd_b_sel];

endmodule

// File: rtl/cpu5_alu.sv
module cpu5_alu
  import cpu5_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [3:0]        op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [DATA_W-1:0] imm,
  output logic [DATA_W-1:0] y
);

  function automatic logic [DATA_W-1:0] alu_eval(
    input logic [3:0]        f_op,
    input logic [DATA_W-1:0] f_a,
    input logic [DATA_W-1:0] f_b,
    input logic [DATA_W-1:0] f_imm
  );
    case (f_op)
      OPC_MOVR: return f_b;
      OPC_MVI:  return f_imm;
      OPC_ADD:  return f_a + f_b;
      OPC_INC:  return f_a + DATA_W'(1);
      default:  return f_a;
    endcase
  endfunction

  assign y = alu_eval(op, a, b, imm);

endmodule

// File: rtl/cpu5_core.sv
module cpu5_core
  import cpu5_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int IP_W    = 16,
  parameter int IP_STEP = 4
) (
  input  logic                clk,
  input  logic                rst,
  output logic [IP_W-1:0]     code_addr,
  input  logic [INSTR_W-1:0]  code_data,
  output logic [DATA_W-1:0]   dmem_addr,
  output logic [DATA_W-1:0]   dmem_wdata,
  input  logic [DATA_W-1:0]   dmem_rdata,
  output logic                dmem_we,
  output logic [2:0]          dbg_state,
  output logic [IP_W-1:0]     dbg_ip,
  output logic [DATA_W-1:0]   dbg_ax,
  output logic [DATA_W-1:0]   dbg_bx
);
  localparam int NREG = 2;

  phase_e phase;

  logic [IP_W-1:0]    ip_q;
  logic [INSTR_W-1:0] ir_q;
  logic [DATA_W-1:0]  opa_q, opb_q, fld_q, res_q, mar_q, mdr_q;

  logic [3:0]         opc;
  logic               sel_dst, sel_src;
  logic [DATA_W-1:0]  rd_a, rd_b, alu_y, wb_data;
  logic [NREG*DATA_W-1:0] q_flat;

  // named events used by the checker
  logic w_is_jmp, w_is_load, w_is_store, w_reg_we;

  assign opc     = word_opc(ir_q);
  assign sel_dst = word_dst(ir_q);
  assign sel_src = word_src(ir_q);

  assign w_is_jmp   = (opc == OPC_JMP);
  assign w_is_load  = (opc == OPC_LOAD);
  assign w_is_store = (opc == OPC_STORE);
  assign w_reg_we   = (phase == ST_WRITE) &&
                      ((opc == OPC_MOVR) || (opc == OPC_LOAD) || (opc == OPC_MVI) ||
                       (opc == OPC_ADD)  || (opc == OPC_INC));

  cpu5_seq u_seq (
    .clk   (clk),
    .rst   (rst),
    .phase (phase)
  );

  cpu5_regs #(.DATA_W(DATA_W), .NREG(NREG)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .rd_a_sel (sel_dst),
    .rd_b_sel (sel_src),
    .rd_a     (rd_a),
    .rd_b     (rd_b),
    .wr_en    (w_reg_we),
    .wr_sel   (sel_dst),
    .wr_data  (wb_data),
    .q_flat   (q_flat)
  );

  cpu5_alu #(.DATA_W(DATA_W)) u_alu (
    .op  (opc),
    .a   (opa_q),
    .b   (opb_q),
    .imm (fld_q),
    .y   (alu_y)
  );

  assign wb_data = w_is_load ? mdr_q : res_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ip_q  <= '0;
      ir_q  <= '0;
      opa_q <= '0;
      opb_q <= '0;
      fld_q <= '0;
      res_q <= '0;
      mar_q <= '0;
      mdr_q <= '0;
    end else begin
      case (phase)
        ST_FETCH: ir_q <= code_data;
        ST_DECODE: begin
          opa_q <= rd_a;
          opb_q <= rd_b;
          fld_q <= DATA_W'(word_field(ir_q));
        end
        ST_EXEC: begin
          res_q <= alu_y;
          if (w_is_load || w_is_store) mar_q <= fld_q;
          if (w_is_store)              mdr_q <= opb_q;
        end
        ST_MEM: begin
          if (w_is_load) mdr_q <= dmem_rdata;
        end
        ST_WRITE: begin
          if (w_is_jmp) ip_q <= IP_W'(fld_q);
          else          ip_q <= ip_q + IP_W'(IP_STEP);
        end
        default: ;
      endcase
    end
  end

  assign code_addr  = ip_q;
  assign dmem_addr  = mar_q;
  assign dmem_wdata = mdr_q;
  assign dmem_we    = (phase == ST_MEM) && w_is_store;

  assign dbg_state = phase;
  assign dbg_ip    = ip_q;
  assign dbg_ax    = q_flat[0 +: DATA_W];
  assign dbg_bx    = q_flat[DATA_W +: DATA_W];

endmodule

// File: rtl/cpu5_chk.sv
module cpu5_chk #(
  parameter int DATA_W  = 16,
  parameter int IP_W    = 16,
  parameter int IP_STEP = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        dbg_state,
  input logic [IP_W-1:0]   dbg_ip,
  input logic [DATA_W-1:0] dbg_ax,
  input logic [DATA_W-1:0] dbg_bx,
  input logic              dmem_we,
  input logic              w_is_jmp,
  input logic              w_reg_we
);

  // R1
  phase_step_chk: assert property (@(posedge clk) disable iff (rst)
    (dbg_state != 3'd4) |=> (dbg_state == $past(dbg_state) + 3'd1));

  // R1
  phase_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (dbg_state == 3'd4) |=> (dbg_state == 3'd0));

  // R5
  store_phase_chk: assert property (@(posedge clk) disable iff (rst)
    dmem_we |-> (dbg_state == 3'd3));

  // R10
  regs_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (dbg_state != 3'd4) |=> ($stable(dbg_ax) && $stable(dbg_bx)));

  // R10
  wb_phase_chk: assert property (@(posedge clk) disable iff (rst)
    w_reg_we |-> (dbg_state == 3'd4));

  // R9
  ip_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (dbg_state != 3'd4) |=> $stable(dbg_ip));

  // R10
  ip_step_chk: assert property (@(posedge clk) disable iff (rst)
    ((dbg_state == 3'd4) && !w_is_jmp) |=> (dbg_ip == $past(dbg_ip) + IP_W'(IP_STEP)));

endmodule

bind cpu5_core cpu5_chk #(.DATA_W(DATA_W), .IP_W(IP_W), .IP_STEP(IP_STEP)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .dbg_state (dbg_state),
  .dbg_ip    (dbg_ip),
  .dbg_ax    (dbg_ax),
  .dbg_bx    (dbg_bx),
  .dmem_we   (dmem_we),
  .w_is_jmp  (w_is_jmp),
  .w_reg_we  (w_reg_we)
);

// File: tb/test_cpu5_core.sv
`timescale 1ns/100ps
module test_cpu5_core;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] code_addr;
  logic [31:0] code_data;
  logic [15:0] dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we;
  logic [2:0]  dbg_state;
  logic [15:0] dbg_ip, dbg_ax, dbg_bx;

  logic [31:0] rom [16];
  logic [15:0] ram [16];

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  cpu5_core i_cpu5_core (
    .clk(clk), .rst(rst), .code_addr(code_addr), .code_data(code_data),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata),
    .dmem_we(dmem_we), .dbg_state(dbg_state), .dbg_ip(dbg_ip),
    .dbg_ax(dbg_ax), .dbg_bx(dbg_bx)
  );

  assign code_data  = rom[code_addr[5:2]];
  assign dmem_rdata = ram[dmem_addr[3:0]];

  always @(posedge clk) if (dmem_we) ram[dmem_addr[3:0]] <= dmem_wdata;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      failures = failures + 1;
      $display("FAIL watchdog: act=%0d exp<=100000 cycles", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic logic [31:0] enc(input logic [3:0] op, input logic d, input logic s,
                                      input logic [15:0] f);
    return {op, d, s, 10'd0, f};
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      failures = failures + 1;
      $display("FAIL %s %s: act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic clear_rom();
    for (int i = 0; i < 16; i++) rom[i] = enc(4'd0, 1'b0, 1'b0, 16'd0);
  endtask

  task automatic start_run();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    // R2: reset state
    check("R2", "phase", {29'd0, dbg_state}, 32'd0);
    check("R2", "ip", {16'd0, dbg_ip}, 32'd0);
    check("R2", "ax", {16'd0, dbg_ax}, 32'd0);
    check("R2", "bx", {16'd0, dbg_bx}, 32'd0);
    rst = 1'b0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  // bench model of one register-only instruction
  function automatic void model(input logic [3:0] op, input logic d, input logic s,
                                input logic [15:0] f, inout logic [15:0] r [2]);
    case (op)
      4'd1: r[d] = r[s];
      4'd4: r[d] = f;
      4'd5: r[d] = r[d] + r[s];
      4'd6: r[d] = r[d] + 16'd1;
      default: ;
    endcase
  endfunction

  initial begin
    logic [15:0] d1, d2, v;
    logic [15:0] mr [2];
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 16; i++) ram[i] = 16'd0;
    clear_rom();

    // Directed: load, load, add, store
    d1 = 16'h0003; d2 = 16'h0005;
    for (int k = 0; k < 6; k++) begin
      if (k > 0) begin d1 = 16'($urandom); d2 = 16'($urandom); end
      if (k == 5) begin d1 = 16'hFFFF; d2 = 16'h0002; end
      ram[1] = d1; ram[2] = d2; ram[4] = 16'h0BAD;
      rom[0] = enc(4'd2, 1'b0, 1'b0, 16'd1);
      rom[1] = enc(4'd2, 1'b1, 1'b0, 16'd2);
      rom[2] = enc(4'd5, 1'b0, 1'b1, 16'd0);
      rom[3] = enc(4'd3, 1'b0, 1'b0, 16'd4);
      start_run();
      if (k == 0) begin
        for (int c = 1; c <= 10; c++) begin
          run(1);
          check("R1", "phase sequence", {29'd0, dbg_state}, 32'(c % 5));
        end
        run(8);
      end else run(18);
      check("R5", "mem[4] before store edge", {16'd0, ram[4]}, 32'h0BAD);
      run(2);
      check("R4", "bx loaded", {16'd0, dbg_bx}, {16'd0, d2});
      check("R7", "ax sum", {16'd0, dbg_ax}, {16'd0, 16'(d1 + d2)});
      check("R5", "mem[4] after 20 cycles", {16'd0, ram[4]}, {16'd0, 16'(d1 + d2)});
      check("R10", "ip after four", {16'd0, dbg_ip}, 32'd16);
    end

    // Write-back timing, mvi, move, increment with wrap
    clear_rom();
    ram[8] = 16'h7777;
    rom[0] = enc(4'd4, 1'b0, 1'b0, 16'h0055);
    rom[1] = enc(4'd6, 1'b0, 1'b0, 16'd0);
    rom[2] = enc(4'd1, 1'b1, 1'b0, 16'd0);
    rom[3] = enc(4'd4, 1'b0, 1'b0, 16'hFFFF);
    rom[4] = enc(4'd6, 1'b0, 1'b0, 16'd0);
    rom[5] = enc(4'd4, 1'b1, 1'b0, 16'd8);
    start_run();
    run(4);
    check("R10", "ax unchanged in phase 4", {16'd0, dbg_ax}, 32'd0);
    check("R10", "ip unchanged in phase 4", {16'd0, dbg_ip}, 32'd0);
    run(1);
    check("R6", "mvi value", {16'd0, dbg_ax}, 32'h0055);
    run(4);
    check("R8", "inc pending", {16'd0, dbg_ax}, 32'h0055);
    run(1);
    check("R8", "inc", {16'd0, dbg_ax}, 32'h0056);
    run(5);
    check("R3", "move ax to bx", {16'd0, dbg_bx}, 32'h0056);
    check("R3", "source kept", {16'd0, dbg_ax}, 32'h0056);
    run(10);
    check("R8", "inc wraps", {16'd0, dbg_ax}, 32'h0000);
    run(5);
    check("R6", "mvi is literal not memory", {16'd0, dbg_bx}, 32'h0008);

    // Store from bx, edge timing
    clear_rom();
    v = 16'($urandom);
    ram[5] = 16'h1111;
    rom[0] = enc(4'd4, 1'b1, 1'b0, v);
    rom[1] = enc(4'd3, 1'b0, 1'b1, 16'd5);
    start_run();
    run(8);
    check("R5", "store not before phase 3 edge", {16'd0, ram[5]}, 32'h1111);
    run(1);
    check("R5", "store of bx", {16'd0, ram[5]}, {16'd0, v});

    // Jump
    clear_rom();
    rom[0] = enc(4'd7, 1'b0, 1'b0, 16'd12);
    rom[1] = enc(4'd4, 1'b0, 1'b0, 16'd1);
    rom[2] = enc(4'd4, 1'b0, 1'b0, 16'd2);
    rom[3] = enc(4'd4, 1'b1, 1'b0, 16'd7);
    start_run();
    run(4);
    check("R9", "ip holds before write-back", {16'd0, dbg_ip}, 32'd0);
    run(1);
    check("R9", "jump target", {16'd0, dbg_ip}, 32'd12);
    run(5);
    check("R9", "skipped code", {16'd0, dbg_ax}, 32'd0);
    check("R9", "target executed", {16'd0, dbg_bx}, 32'd7);
    check("R10", "step after target", {16'd0, dbg_ip}, 32'd16);

    // Undefined opcodes and reserved bits
    clear_rom();
    ram[4] = 16'hAAAA;
    rom[0] = enc(4'd4, 1'b0, 1'b0, 16'h1234);
    rom[1] = enc(4'hF, 1'b0, 1'b0, 16'd4);
    rom[2] = enc(4'd6, 1'b0, 1'b0, 16'd0) | 32'h0001_0000;
    rom[3] = enc(4'd3, 1'b0, 1'b0, 16'd4) | 32'h0200_0000;
    rom[4] = enc(4'd0, 1'b1, 1'b0, 16'd4);
    start_run();
    run(25);
    check("R11", "ax untouched", {16'd0, dbg_ax}, 32'h1234);
    check("R11", "bx untouched", {16'd0, dbg_bx}, 32'h0000);
    check("R11", "no memory write", {16'd0, ram[4]}, 32'hAAAA);
    check("R11", "ip stepped", {16'd0, dbg_ip}, 32'd20);

    // Random register programs against bench model
    for (int t = 0; t < 25; t++) begin
      logic [3:0] ops [4];
      logic       ds [4], ss [4];
      logic [15:0] fs [4];
      clear_rom();
      mr[0] = 16'd0; mr[1] = 16'd0;
      for (int j = 0; j < 4; j++) begin
        case ($urandom % 4)
          0: ops[j] = 4'd4;
          1: ops[j] = 4'd1;
          2: ops[j] = 4'd5;
          default: ops[j] = 4'd6;
        endcase
        if (j == 0) ops[j] = 4'd4;
        ds[j] = 1'($urandom); ss[j] = 1'($urandom); fs[j] = 16'($urandom);
        rom[j] = enc(ops[j], ds[j], ss[j], fs[j]);
        model(ops[j], ds[j], ss[j], fs[j], mr);
      end
      start_run();
      run(20);
      check("R7", "random program ax", {16'd0, dbg_ax}, {16'd0, mr[0]});
      check("R3", "random program bx", {16'd0, dbg_bx}, {16'd0, mr[1]});
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule